// File: doc/BRIEF.md
# ADC Two-Wire Readout Interface Controller

This block is the converter-side logic for a two-wire serial readout port. The host drives a serial clock input. The block drives one output line that does two jobs: it signals that a result is ready, and it carries the data. The block runs on a fast system clock and samples the serial clock through a synchronizer. The conversion engine gives it a 20-bit two's-complement result together with a one-cycle done strobe. The host reads the result by giving clock pulses.

There is no command register. The host gives commands only through how it uses the serial clock. Extra pulses after the data request a calibration. Holding the clock high requests sleep. Releasing the clock from a long high phase wakes the block. On wake the block tells the conversion engine either to restart conversion or to calibrate first, using one-cycle pulses.

Top module: `adc2w_readout`

## Requirements
- R1: After reset the output line is high, `sleep_o` is low, and neither `cal_start` nor `conv_restart` has pulsed.
- R2: A `conv_done` strobe while the port is idle drives the output line low within four system clocks.
- R3: Once the line is low, serial clock rising edges 1 to 20 put result bits 19 down to 0 on the line, most significant first. Rising edges 21 to 24 put out 0.
- R4: The 25th rising edge drives the line high. If the 25th edge is not given, the line keeps the last bit it shifted out for as long as the serial clock stays low.
- R5: A 26th pulse produces exactly one `cal_start` pulse, and only after that pulse's falling edge. The line stays high until the next result arrives.
- R6: When a second result arrives before any bit of the first has been read, the read returns the second result.
- R7: A result that arrives during a read (edge count 1 to 24) does not disturb that read. The read completes with the old bits. The line goes low again right after the 25th edge, and the new result is then read.
- R8: Holding the serial clock high for more than `SLEEP_CYC` system clocks puts the block to sleep. This works at any point after a result was made ready, including in the middle of a read. While asleep, `sleep_o` is high and the line is high.
- R9: A falling serial clock ends sleep. `sleep_o` drops and exactly one `conv_restart` pulse is sent, with no `cal_start`.
- R10: If the pulse held high for sleep was the 26th, waking sends one `cal_start` pulse instead of `conv_restart`.
- R11: Serial clock pulses, or a long high phase, with no result made ready since reset, do not change the line, do not pulse anything, and do not enter sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Host serial clock, asynchronous to clk |
| conv_done | input | 1 | One-cycle strobe: a new result is on conv_data |
| conv_data | input | DATA_W | Two's-complement conversion result |
| dout | output | 1 | Combined ready flag (low) and serial data line |
| sleep_o | output | 1 | High while the block is asleep |
| cal_start | output | 1 | One-cycle request to run a self-calibration |
| conv_restart | output | 1 | One-cycle request to restart conversion after sleep |

## Verification
The assertions assume the host holds each serial clock level for several system clocks, so that the synchronizer sees every edge. The stimulus holds each phase for eight clocks. The assertions also assume that the long-high phase used for sleep is the only phase longer than `SLEEP_CYC`. The stimulus keeps normal phases far shorter than the reduced sleep limit it uses, and only exceeds that limit on purpose. The assertions further assume the engine pulses `conv_done` for one clock at a time and never while the block is asleep. The bench follows this: it delivers a result only while the block is awake.

// File: rtl/adc2w_pkg.sv
package adc2w_pkg;
   // Action taken by the conversion engine when the port leaves sleep
   typedef enum logic {
      WAKE_CONVERT   = 1'b0,
      WAKE_CALIBRATE = 1'b1
   } wake_act_e;

   localparam int unsigned ADC2W_MIN_SYNC  = 2;
   localparam int unsigned ADC2W_MIN_SLEEP = 4;
endpackage

// File: rtl/adc2w_sync.sv
module adc2w_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/adc2w_hold_timer.sv
module adc2w_hold_timer #(
   parameter int unsigned LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic hit
);
   localparam int unsigned TW = $clog2(LIMIT + 1);
   localparam logic [TW-1:0] TOP  = TW'(LIMIT);
   localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

   logic [TW-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run <= '0;
      else if (!level)     run <= '0;
      else if (run != TOP) run <= run + 1'b1;
   end

   // one-cycle strobe when the high phase outlasts the limit
   assign hit = level && (run == LAST);
endmodule

// File: rtl/adc2w_shifter.sv
module adc2w_shifter #(
   parameter int unsigned DATA_W  = 20,
   parameter int unsigned FRAME_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              shift,
   output logic              msb
);
   logic [FRAME_W-1:0] frame;
   logic [FRAME_W-1:0] fill;

   generate
      if (FRAME_W > DATA_W) begin : g_pad
         assign fill = {load_data, {(FRAME_W-DATA_W){1'b0}}};
      end else begin : g_exact
         assign fill = load_data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     frame <= '0;
      else if (load)  frame <= fill;
      else if (shift) frame <= {frame[FRAME_W-2:0], 1'b0};
   end

   assign msb = frame[FRAME_W-1];
endmodule

// File: rtl/adc2w_readout.sv
module adc2w_readout
   import adc2w_pkg::*;
#(
   parameter int unsigned DATA_W      = 20,
   parameter int unsigned FRAME_W     = 24,
   parameter int unsigned SLEEP_CYC   = 1024,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_in,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   output logic              dout,
   output logic              sleep_o,
   output logic              cal_start,
   output logic              conv_restart
);
   localparam int unsigned END_POS = FRAME_W + 1;
   localparam int unsigned CAL_POS = FRAME_W + 2;
   localparam int unsigned CNT_W   = $clog2(CAL_POS + 1);
   localparam logic [CNT_W-1:0] FRAME_V = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] END_V   = CNT_W'(END_POS);
   localparam logic [CNT_W-1:0] CAL_V   = CNT_W'(CAL_POS);

   generate
      if (FRAME_W < DATA_W) begin : g_bad_frame
         $error("FRAME_W must be at least DATA_W");
      end
      if (SYNC_STAGES < ADC2W_MIN_SYNC) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (SLEEP_CYC < ADC2W_MIN_SLEEP) begin : g_bad_sleep
         $error("SLEEP_CYC too small");
      end
   endgenerate

   logic              sclk_s, sclk_q, rise, fall, hold_hit, msb;
   logic [CNT_W-1:0]  pos;
   logic              rdy, seen, asleep, line;
   wake_act_e         wake_act;
   logic              pend_valid;
   logic [DATA_W-1:0] pend_data;
   logic              load_ok, rise_ok, go_sleep, shift_en;

   adc2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sclk_in), .q(sclk_s)
   );

   adc2w_hold_timer #(.LIMIT(SLEEP_CYC)) u_hold (
      .clk(clk), .rst_n(rst_n), .level(sclk_s), .hit(hold_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   assign rise     = sclk_s && !sclk_q;
   assign fall     = !sclk_s && sclk_q;
   assign go_sleep = !asleep && hold_hit && seen;
   assign rise_ok  = rise && !asleep && (pos != '0 || rdy) && (pos != CAL_V);
   assign load_ok  = pend_valid && !asleep && !go_sleep && !rise && !fall &&
                     (pos == '0 || pos == END_V);
   assign shift_en = rise_ok && (pos < FRAME_V);

   adc2w_shifter #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load_ok), .load_data(pend_data),
      .shift(shift_en), .msb(msb)
   );

   // newest result is always kept; an older unread one is dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_data  <= '0;
      end else if (conv_done) begin
         pend_valid <= 1'b1;
         pend_data  <= conv_data;
      end else if (load_ok) begin
         pend_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos          <= '0;
         rdy          <= 1'b0;
         seen         <= 1'b0;
         asleep       <= 1'b0;
         wake_act     <= WAKE_CONVERT;
         line         <= 1'b1;
         cal_start    <= 1'b0;
         conv_restart <= 1'b0;
      end else begin
         cal_start    <= 1'b0;
         conv_restart <= 1'b0;
         if (asleep) begin
            if (fall) begin
               asleep <= 1'b0;
               if (wake_act == WAKE_CALIBRATE) cal_start    <= 1'b1;
               else                            conv_restart <= 1'b1;
            end
         end else if (go_sleep) begin
            asleep   <= 1'b1;
            line     <= 1'b1;
            rdy      <= 1'b0;
            seen     <= 1'b0;
            pos      <= '0;
            wake_act <= (pos == CAL_V) ? WAKE_CALIBRATE : WAKE_CONVERT;
         end else if (rise_ok) begin
            rdy  <= 1'b0;
            pos  <= pos + 1'b1;
            line <= (pos < FRAME_V) ? msb : 1'b1;
         end else if (fall && pos == CAL_V) begin
            cal_start <= 1'b1;
            pos       <= '0;
         end else if (load_ok) begin
            line <= 1'b0;
            rdy  <= 1'b1;
            seen <= 1'b1;
            pos  <= '0;
         end
      end
   end

   assign dout    = line;
   assign sleep_o = asleep;
endmodule

// File: rtl/adc2w_readout_chk.sv
module adc2w_readout_chk (
   input logic clk,
   input logic rst_n,
   input logic dout,
   input logic sleep_o,
   input logic cal_start,
   input logic conv_restart
);
   // R8
   sleep_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_o |-> dout);

   // R9
   wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_o) |-> (cal_start || conv_restart));

   // R10
   wake_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cal_start && conv_restart));

   // R5
   cal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |=> !cal_start);

   // R9
   restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_restart |=> !conv_restart);

   // R8
   no_req_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_o |-> (!cal_start && !conv_restart));
endmodule

bind adc2w_readout adc2w_readout_chk u_chk (
   .clk(clk), .rst_n(rst_n), .dout(dout), .sleep_o(sleep_o),
   .cal_start(cal_start), .conv_restart(conv_restart)
);

// File: tb/adc2w_readout_bench.sv
module adc2w_readout_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 20;
   localparam int SLP = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk_in = 1'b0;
   logic conv_done = 1'b0;
   logic [DW-1:0] conv_data = '0;
   logic dout, sleep_o, cal_start, conv_restart;

   int total = 0;
   int bad = 0;
   int n_cal = 0;
   int n_rst = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc2w_readout #(.DATA_W(DW), .FRAME_W(24), .SLEEP_CYC(SLP), .SYNC_STAGES(2)) u_adc2w_readout (
      .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .conv_done(conv_done),
      .conv_data(conv_data), .dout(dout), .sleep_o(sleep_o),
      .cal_start(cal_start), .conv_restart(conv_restart)
   );

   always @(posedge clk) begin
      if (rst_n && cal_start)    n_cal++;
      if (rst_n && conv_restart) n_rst++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic deliver(input logic [DW-1:0] d);
      @(negedge clk);
      conv_done = 1'b1;
      conv_data = d;
      @(negedge clk);
      conv_done = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // one full pulse; v is the line seen during the high phase
   task automatic pulse(output logic v);
      @(negedge clk);
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
      v = dout;
      repeat (2) @(negedge clk);
      sclk_in = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic read_bits(input logic [DW-1:0] d, input int first, input int last, input string req);
      logic v;
      for (int i = first; i <= last; i++) begin
         logic e;
         e = (i <= DW) ? d[DW-i] : 1'b0;
         pulse(v);
         check(v === e, req, int'(v), int'(e));
      end
   endtask

   task automatic full_read(input logic [DW-1:0] d, input string req);
      logic v;
      deliver(d);
      check(dout === 1'b0, "R2 ready low", int'(dout), 0);
      read_bits(d, 1, 24, req);
      pulse(v);
      check(v === 1'b1, "R4 25th high", int'(v), 1);
   endtask

   task automatic hold_high(input int cyc);
      @(negedge clk);
      sclk_in = 1'b1;
      repeat (cyc) @(negedge clk);
   endtask

   task automatic release_low();
      @(negedge clk);
      sclk_in = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic v;
      int c0, r0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset state
      check(dout === 1'b1, "R1 line", int'(dout), 1);
      check(sleep_o === 1'b0, "R1 sleep", int'(sleep_o), 0);
      check(n_cal == 0 && n_rst == 0, "R1 pulses", n_cal + n_rst, 0);

      // R11 activity with nothing ready
      for (int k = 0; k < 3; k++) begin
         pulse(v);
         check(v === 1'b1, "R11 idle pulse", int'(v), 1);
      end
      hold_high(SLP + 40);
      check(sleep_o === 1'b0, "R11 no sleep", int'(sleep_o), 0);
      check(dout === 1'b1, "R11 line", int'(dout), 1);
      release_low();
      check(n_cal == 0 && n_rst == 0, "R11 no pulses", n_cal + n_rst, 0);

      // R3 sweep over corner values and walking ones
      full_read(20'h00000, "R3 zero");
      full_read(20'h7FFFF, "R3 max pos");
      full_read(20'h80000, "R3 min neg");
      full_read(20'hFFFFF, "R3 minus one");
      full_read(20'hA5A5A, "R3 pattern");
      for (int b = 0; b < DW; b++) full_read(DW'(1) << b, "R3 walking");

      // R4 no 25th edge: line holds last bit
      deliver(20'h00001);
      read_bits(20'h00001, 1, 20, "R4 partial");
      repeat (200) @(negedge clk);
      check(dout === 1'b1, "R4 hold last", int'(dout), 1);
      read_bits(20'h00001, 21, 24, "R4 tail");
      repeat (200) @(negedge clk);
      check(dout === 1'b0, "R4 hold pad", int'(dout), 0);
      pulse(v);
      check(v === 1'b1, "R4 25th", int'(v), 1);

      // R6 overwrite before read
      deliver(20'h12345);
      deliver(20'h6789A);
      read_bits(20'h6789A, 1, 24, "R6 newest");
      pulse(v);

      // R7 result arriving mid-read
      deliver(20'h3C3C3);
      read_bits(20'h3C3C3, 1, 10, "R7 before");
      deliver(20'h5AA55);
      read_bits(20'h3C3C3, 11, 24, "R7 old kept");
      pulse(v);
      repeat (4) @(negedge clk);
      check(dout === 1'b0, "R7 new ready", int'(dout), 0);
      read_bits(20'h5AA55, 1, 24, "R7 new read");
      pulse(v);

      // R5 26th pulse requests calibration on its falling edge
      deliver(20'h0F0F0);
      read_bits(20'h0F0F0, 1, 24, "R5 read");
      pulse(v);
      c0 = n_cal;
      hold_high(8);
      check(n_cal == c0, "R5 not at rise", n_cal, c0);
      check(dout === 1'b1, "R5 line high", int'(dout), 1);
      release_low();
      check(n_cal == c0 + 1, "R5 cal pulse", n_cal, c0 + 1);
      check(dout === 1'b1, "R5 line after", int'(dout), 1);
      full_read(20'h13579, "R5 post-cal data");

      // R8 sleep during partial read, R9 wake
      deliver(20'hFEDCB);
      read_bits(20'hFEDCB, 1, 5, "R8 partial");
      c0 = n_cal;
      r0 = n_rst;
      hold_high(SLP + 40);
      check(sleep_o === 1'b1, "R8 asleep", int'(sleep_o), 1);
      check(dout === 1'b1, "R8 line", int'(dout), 1);
      release_low();
      check(sleep_o === 1'b0, "R9 awake", int'(sleep_o), 0);
      check(n_rst == r0 + 1, "R9 restart", n_rst, r0 + 1);
      check(n_cal == c0, "R9 no cal", n_cal, c0);
      full_read(20'h24680, "R9 next data");

      // R10 26th pulse held high: calibrate on wake
      deliver(20'h11111);
      read_bits(20'h11111, 1, 24, "R10 read");
      pulse(v);
      c0 = n_cal;
      r0 = n_rst;
      hold_high(SLP + 40);
      check(sleep_o === 1'b1, "R10 asleep", int'(sleep_o), 1);
      check(n_cal == c0, "R10 no early cal", n_cal, c0);
      release_low();
      check(n_cal == c0 + 1, "R10 wake cal", n_cal, c0 + 1);
      check(n_rst == r0, "R10 no restart", n_rst, r0);
      full_read(20'h80001, "R10 post-cal data");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule